// File: doc/BRIEF.md
# Reciprocal frequency counter core

This block measures the frequency of a logic-level square wave with the equal-precision method. A free-running divider of the reference clock produces a preset gate of fixed length (about 0.1 s with the default parameters at a 5 MHz reference). A flop clocked by the measured signal re-times that gate. The real measurement window therefore starts and ends on rising edges of the measured signal and covers a whole number of its periods. During the window the input-domain counter counts measured-signal periods (Nx). A reference-domain counter counts reference cycles (Ns) for as long as a two-flop synchronised copy of the window is high.

When the window closes, both counts are copied into holding registers and a one-cycle done strobe is raised in the reference domain. Downstream logic computes the frequency as f_ref * Nx / Ns. Nx carries no ±1 error, so the relative error is about 1/Ns whatever the measured frequency. With the default parameters Ns is about 500000. The supported input range is 100 Hz to 10 MHz, and a fresh result appears about every 0.2 s.

Top module: `fc_reciprocal_core`

## Requirements
- R1: While `rst_n` is low, `nx_count`, `ns_count` and `meas_done` are 0. The reset takes effect asynchronously. Each clock domain leaves reset on the second rising edge of its own clock after `rst_n` rises.
- R2: The preset gate starts low and toggles after every PRESCALE*GATE_TICKS reference cycles. These cycles are counted from the third reference rising edge after `rst_n` rises. An internal counter wraps at terminal value GATE_TICKS-1 of the prescaled tick.
- R3: The window opens and closes only on rising edges of `sig_in`. Nx equals the number of `sig_in` rising edges at which the re-timed window was already high, which is the number of whole input periods in the window.
- R4: Ns equals the number of reference rising edges at which the two-flop synchronised window was high.
- R5: Take the first reference edge that samples the re-timed window low after it was high. `meas_done` is high for exactly one reference cycle, beginning at the second reference edge after that edge. New Nx and Ns values appear on the outputs in that same cycle.
- R6: `nx_count` and `ns_count` keep their values in every cycle in which `meas_done` is low.
- R7: For a steady input of period Tsig, every result satisfies |Ns*Tref − Nx*Tsig| < Tref.
- R8: With NX_W and NS_W at their defaults of 24 bits, neither counter can wrap inside a window at the default gate length, even at 10 MHz.
- R9: A reset asserted while a window is open aborts it. No done strobe follows for that window, the outputs read 0, and measurement restarts from the start of the gate sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; time base for Ns and for the preset gate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| sig_in | input | 1 | Square wave being measured; clocks the gate re-timing flop and Nx |
| nx_count | output | NX_W | Held count of whole input periods in the last window |
| ns_count | output | NS_W | Held count of reference cycles in the last window |
| meas_done | output | 1 | One-cycle strobe in the reference domain when new counts are held |

## Verification
The hardest situation to reach from the ports is a reset that lands while a window is open in both clock domains. It must leave no stale strobe in the two-stage path from the falling-edge detector to `meas_done`. The bench uses a short gate and waits a fixed number of reference cycles after a done strobe, so that the next window is known to be open. It then pulses `rst_n` between clock edges and checks that outputs stay at zero and that the following result has a fresh gate sequence behind it. Input periods are whole nanoseconds on a half-nanosecond phase, so no input edge ever coincides with a reference edge. They range from just under one reference period to several reference periods, which exercises both the fine and the coarse ratio of Nx to Ns.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
  // default divider: 100 reference cycles per tick, 5000 ticks per gate half
  localparam int unsigned FC_DEF_PRESCALE   = 100;
  localparam int unsigned FC_DEF_GATE_TICKS = 5000;
  // default counter widths (no wrap at 10 MHz over a 0.1 s window)
  localparam int unsigned FC_DEF_NX_W       = 24;
  localparam int unsigned FC_DEF_NS_W       = 24;
endpackage

// File: rtl/fc_rst_sync.sv
`timescale 1ns/1ps
module fc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/fc_gate_gen.sv
`timescale 1ns/1ps
module fc_gate_gen #(
  parameter int unsigned PRESCALE   = 100,
  parameter int unsigned GATE_TICKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_o
);
  localparam int unsigned GT_W = (GATE_TICKS > 1) ? $clog2(GATE_TICKS) : 1;
  localparam logic [GT_W-1:0] GT_LAST = GT_W'(GATE_TICKS - 1);

  logic            tick;
  logic            wrap;
  logic [GT_W-1:0] gcnt_q, gcnt_d;
  logic            gate_q, gate_d;

  generate
    if (PRESCALE > 1) begin : g_prescale
      localparam int unsigned PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] ps_q, ps_d;

      always_comb begin
        if (ps_q == PS_LAST) ps_d = '0;
        else                 ps_d = ps_q + PS_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
      end

      assign tick = (ps_q == PS_LAST);
    end else begin : g_no_prescale
      assign tick = 1'b1;
    end
  endgenerate

  assign wrap = tick && (gcnt_q == GT_LAST);

  always_comb begin
    gcnt_d = gcnt_q;
    gate_d = gate_q;
    if (tick) begin
      if (wrap) begin
        gcnt_d = '0;
        gate_d = ~gate_q;
      end else begin
        gcnt_d = gcnt_q + GT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      gate_q <= 1'b0;
    end else begin
      gcnt_q <= gcnt_d;
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;

  // R2
  gate_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> $past(wrap));
endmodule

// File: rtl/fc_sig_count.sv
`timescale 1ns/1ps
module fc_sig_count #(
  parameter int unsigned NX_W = 24
) (
  input  logic            sig_clk,
  input  logic            sig_rst_n,
  input  logic            gate_pre_i,
  output logic            gate_o,
  output logic [NX_W-1:0] nx_o
);
  logic            gate_q, gate_d;
  logic [NX_W-1:0] nx_q, nx_d;
  logic            opening;

  assign opening = !gate_q && gate_pre_i;

  always_comb begin
    gate_d = gate_pre_i;
    nx_d   = nx_q;
    if (opening)     nx_d = '0;
    else if (gate_q) nx_d = nx_q + NX_W'(1);
  end

  always_ff @(posedge sig_clk or negedge sig_rst_n) begin
    if (!sig_rst_n) begin
      gate_q <= 1'b0;
      nx_q   <= '0;
    end else begin
      gate_q <= gate_d;
      nx_q   <= nx_d;
    end
  end

  assign gate_o = gate_q;
  assign nx_o   = nx_q;

  // R8
  nx_no_overflow_chk: assert property (@(posedge sig_clk) disable iff (!sig_rst_n)
    gate_q |-> (nx_q != '1));

  // R3
  nx_close_chk: assert property (@(posedge sig_clk) disable iff (!sig_rst_n)
    $fell(gate_q) |-> (nx_q != '0));
endmodule

// File: rtl/fc_ref_count.sv
`timescale 1ns/1ps
module fc_ref_count #(
  parameter int unsigned NX_W = 24,
  parameter int unsigned NS_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate_sig_i,
  input  logic [NX_W-1:0] nx_i,
  output logic [NX_W-1:0] nx_hold_o,
  output logic [NS_W-1:0] ns_hold_o,
  output logic            done_o
);
  logic            g1_q, g2_q, gd_q;
  logic            rise, fall;
  logic [NS_W-1:0] ns_q, ns_d;
  logic [NS_W-1:0] hold_ns_q, hold_ns_d;
  logic [NX_W-1:0] hold_nx_q, hold_nx_d;
  logic            done_q, done_d;

  assign rise = g2_q && !gd_q;
  assign fall = !g2_q && gd_q;

  always_comb begin
    ns_d      = ns_q;
    hold_ns_d = hold_ns_q;
    hold_nx_d = hold_nx_q;
    done_d    = fall;
    if (rise)      ns_d = NS_W'(1);
    else if (g2_q) ns_d = ns_q + NS_W'(1);
    // Nx is quiet once the input-domain window has closed, well before fall
    if (fall) begin
      hold_ns_d = ns_q;
      hold_nx_d = nx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q      <= 1'b0;
      g2_q      <= 1'b0;
      gd_q      <= 1'b0;
      ns_q      <= '0;
      hold_ns_q <= '0;
      hold_nx_q <= '0;
      done_q    <= 1'b0;
    end else begin
      g1_q      <= gate_sig_i;
      g2_q      <= g1_q;
      gd_q      <= g2_q;
      ns_q      <= ns_d;
      hold_ns_q <= hold_ns_d;
      hold_nx_q <= hold_nx_d;
      done_q    <= done_d;
    end
  end

  assign nx_hold_o = hold_nx_q;
  assign ns_hold_o = hold_ns_q;
  assign done_o    = done_q;

  // R8
  ns_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g2_q |-> (ns_q != '1));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hold_ns_q) || !$stable(hold_nx_q)) |-> done_q);

  // R4
  ns_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (hold_ns_q != '0));
endmodule

// File: rtl/fc_reciprocal_core.sv
`timescale 1ns/1ps
module fc_reciprocal_core
  import fc_pkg::*;
#(
  parameter int unsigned PRESCALE   = FC_DEF_PRESCALE,
  parameter int unsigned GATE_TICKS = FC_DEF_GATE_TICKS,
  parameter int unsigned NX_W       = FC_DEF_NX_W,
  parameter int unsigned NS_W       = FC_DEF_NS_W
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic            sig_in,
  output logic [NX_W-1:0] nx_count,
  output logic [NS_W-1:0] ns_count,
  output logic            meas_done
);
  logic            ref_rst_n;
  logic            sig_rst_n;
  logic            gate_pre;
  logic            gate_sig;
  logic [NX_W-1:0] nx_live;

  fc_rst_sync i_ref_rst (
    .clk     (clk_ref),
    .arst_n  (rst_n),
    .rst_n_o (ref_rst_n)
  );

  fc_rst_sync i_sig_rst (
    .clk     (sig_in),
    .arst_n  (rst_n),
    .rst_n_o (sig_rst_n)
  );

  fc_gate_gen #(
    .PRESCALE   (PRESCALE),
    .GATE_TICKS (GATE_TICKS)
  ) i_gate_gen (
    .clk    (clk_ref),
    .rst_n  (ref_rst_n),
    .gate_o (gate_pre)
  );

  fc_sig_count #(
    .NX_W (NX_W)
  ) i_sig_count (
    .sig_clk    (sig_in),
    .sig_rst_n  (sig_rst_n),
    .gate_pre_i (gate_pre),
    .gate_o     (gate_sig),
    .nx_o       (nx_live)
  );

  fc_ref_count #(
    .NX_W (NX_W),
    .NS_W (NS_W)
  ) i_ref_count (
    .clk        (clk_ref),
    .rst_n      (ref_rst_n),
    .gate_sig_i (gate_sig),
    .nx_i       (nx_live),
    .nx_hold_o  (nx_count),
    .ns_hold_o  (ns_count),
    .done_o     (meas_done)
  );
endmodule

// File: tb/test_fc_reciprocal_core.sv
`timescale 1ns/1ps
module test_fc_reciprocal_core;
  localparam int CLK_PERIOD_NS = 10;
  localparam int PRESCALE      = 3;
  localparam int GATE_TICKS    = 20;
  localparam int NX_W          = 24;
  localparam int NS_W          = 24;
  localparam longint GATE_LEN  = PRESCALE * GATE_TICKS;

  logic            clk_ref;
  logic            rst_n;
  logic            sig_in;
  logic [NX_W-1:0] nx_count;
  logic [NS_W-1:0] ns_count;
  logic            meas_done;

  fc_reciprocal_core #(
    .PRESCALE   (PRESCALE),
    .GATE_TICKS (GATE_TICKS),
    .NX_W       (NX_W),
    .NS_W       (NS_W)
  ) i_fc_reciprocal_core (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .sig_in    (sig_in),
    .nx_count  (nx_count),
    .ns_count  (ns_count),
    .meas_done (meas_done)
  );

  int n_cmp  = 0;
  int n_fail = 0;
  int sig_period = 30;
  int r7_skip = 0;
  int done_seen = 0;
  string reset_tag = "R1";

  initial begin
    clk_ref = 1'b0;
    forever #(CLK_PERIOD_NS / 2) clk_ref = ~clk_ref;
  end

  // input edges always fall on x.5 ns, reference edges on whole ns
  initial begin
    sig_in = 1'b0;
    #0.5;
    forever begin
      #(sig_period - sig_period / 2) sig_in = 1'b1;
      #(sig_period / 2) sig_in = 1'b0;
    end
  end

  // ---------------- behavioural reference model ----------------
  longint ref_edges;
  int     ref_rel;
  int     sig_rel;
  bit     pre_m;
  bit     sync_m;
  bit     prev_s;
  longint run_m;
  longint nx_m;
  bit     p0_v, p1_v;
  longint p0_ns, p0_nx, p1_ns, p1_nx;
  bit     done_exp;
  longint exp_nx, exp_ns;

  // input domain: window follows the preset gate at input rising edges (R3)
  always @(posedge sig_in or negedge rst_n) begin
    if (!rst_n) begin
      sig_rel = 0; sync_m = 1'b0; nx_m = 0;
    end else if (sig_rel < 2) begin
      sig_rel = sig_rel + 1;
    end else begin
      if (sync_m) nx_m = nx_m + 1;
      if (!sync_m && pre_m) nx_m = 0;
      sync_m = pre_m;
    end
  end

  // reference domain: preset gate (R2), Ns (R4), done timing (R5)
  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ref_edges = 0; ref_rel = 0; pre_m = 1'b0; prev_s = 1'b0; run_m = 0;
      p0_v = 0; p1_v = 0; p0_ns = 0; p0_nx = 0; p1_ns = 0; p1_nx = 0;
      done_exp = 0; exp_nx = 0; exp_ns = 0;
    end else if (ref_rel < 2) begin
      ref_rel = ref_rel + 1;
    end else begin
      done_exp = p1_v;
      if (p1_v) begin
        exp_ns = p1_ns; exp_nx = p1_nx; done_seen = done_seen + 1;
      end
      p1_v = p0_v; p1_ns = p0_ns; p1_nx = p0_nx;
      p0_v = 1'b0;
      if (sync_m) begin
        run_m = run_m + 1;
      end else if (prev_s) begin
        p0_v = 1'b1; p0_ns = run_m; p0_nx = nx_m; run_m = 0;
      end
      prev_s = sync_m;
      ref_edges = ref_edges + 1;
      pre_m = ((ref_edges / GATE_LEN) % 2) == 1;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp = n_cmp + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // compare on every reference cycle, away from the active edge
  always @(negedge clk_ref) begin
    if (!rst_n) begin
      check({reset_tag, " done in reset"}, meas_done, 0);
      check({reset_tag, " nx in reset"}, nx_count, 0);
      check({reset_tag, " ns in reset"}, ns_count, 0);
    end else begin
      check("R2/R5 done strobe", meas_done, done_exp);
      check("R3/R6 nx_count", nx_count, exp_nx);
      check("R4/R6 ns_count", ns_count, exp_ns);
      if (meas_done && done_exp) begin
        if (r7_skip > 0) r7_skip = r7_skip - 1;
        else begin
          longint diff;
          diff = longint'(ns_count) * CLK_PERIOD_NS - longint'(nx_count) * sig_period;
          if (diff < 0) diff = -diff;
          // R7 reciprocal relation
          check("R7 |Ns*Tref-Nx*Tsig|<Tref", (diff < CLK_PERIOD_NS) ? 1 : 0, 1);
        end
      end
    end
  end

  task automatic wait_done(input int n);
    int target;
    target = done_seen + n;
    wait (done_seen >= target);
    @(negedge clk_ref);
  endtask

  task automatic set_period(input int p);
    sig_period = p;
    r7_skip = 1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    // R1: reset state
    #52 rst_n = 1'b1;
    reset_tag = "R9";
    set_period(30);
    wait_done(3);
    set_period(7);   // faster than the reference clock
    wait_done(3);
    set_period(83);  // several reference cycles per input period
    wait_done(3);
    set_period(13);
    wait_done(2);
    // R9: reset while a window is open in both domains
    repeat (90) @(negedge clk_ref);
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk_ref);
    #2 rst_n = 1'b1;
    r7_skip = 0;
    wait_done(2);
    set_period(51);
    wait_done(2);
    // R8 holds by the counter assertions throughout
    finish_run();
  end
endmodule